// File: doc/BRIEF.md
# Normalizing Shift-Subtract Unsigned Divider

This block divides one unsigned W-bit integer by another over several clock cycles. A one-cycle `start` pulse captures both operands. The block first scales the divisor up by powers of two until it is as large as possible without exceeding the dividend. A one-hot position marker moves up with it. The block then walks back down one binary position per cycle. At each position it subtracts the scaled divisor when the partial remainder allows and adds the marker into the quotient. The run ends once the marker is back at bit 0.

Because the block only scales the divisor as far as the operands require, small quotients finish in a few cycles and the cycle count depends on the data. When the divisor is zero, the block skips all iteration and reports the condition at once. The quotient, remainder and zero-divisor flag hold their values until the next accepted `start`.

Top module: `shiftSubDivider`

## Requirements
- R1: When the divisor is nonzero, the completed quotient equals the dividend divided by the divisor truncated toward zero, and the remainder equals the dividend minus quotient times divisor. The remainder is always smaller than the divisor.
- R2: When `start` is accepted with a zero divisor, `done` and `divByZero` go high in the next cycle. `quotient` is all ones, `remainder` equals the dividend, and `busy` never rises. `divByZero` is low after any other operation.
- R3: After an accepted nonzero-divisor `start`, `busy` is high from the next cycle until the result is ready. `done` is high for exactly one cycle, and during that cycle `busy` is low.
- R4: A `start` pulse while `busy` is high is ignored: no extra `done` occurs and the running result is not disturbed.
- R5: For a nonzero divisor, `busy` stays high for exactly 2*s+2 cycles. Here s is the number of left shifts, which is the largest s with divisor*2^s not above the dividend (s = 0 when the divisor exceeds the dividend).
- R6: A dividend smaller than the divisor gives quotient 0 and remainder equal to the dividend after a single subtract step, so `busy` lasts 2 cycles.
- R7: Scaling never shifts out a set divisor bit. A divisor with its top bit set is never scaled and still divides correctly.
- R8: After reset, `busy`, `done`, `divByZero`, `quotient` and `remainder` are all 0.
- R9: The position marker is always one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; operands are sampled with it |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient (all ones on zero divisor) |
| remainder | output | W | Remainder (dividend on zero divisor) |
| divByZero | output | 1 | Last operation had a zero divisor |

## Verification
The assertions check several properties on every cycle:
- the marker stays one-hot;
- the divisor register never scales with its top bit set;
- `done` never lasts two cycles;
- an accepted start leads to `busy`, or to the immediate zero-divisor completion;
- the finishing step always leaves a remainder below the divisor.

Only the bench scenarios can show that the numbers are right and that the data-dependent cycle count matches 2*s+2. These scenarios cover random operands, zero, one, all-ones, equal operands, top-bit divisors and a start pulse issued mid-run.

// File: rtl/divPkg.sv
package divPkg;
  // Strobes sent from the sequencer to the datapath each cycle
  typedef struct packed {
    logic load;      // capture operands, clear quotient, marker to bit 0
    logic loadZero;  // capture zero-divisor result
    logic shiftL;    // scale divisor and marker up one place
    logic step;      // trial subtract at current position
    logic lastStep;  // marker already at bit 0: do not shift down
  } divStrobes_t;
endpackage

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  divStrobes_t  strb,
  input  logic [W-1:0] dividendIn,
  input  logic [W-1:0] divisorIn,
  output logic         canShift,
  output logic         markerAtBase,
  output logic         divisorZero,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         divByZero
);
  localparam int WX = W + 1;

  logic [W-1:0] remReg, divReg, quotReg, marker;
  logic         dbzReg;
  logic [WX-1:0] scaledNext;
  logic          fits;

  assign scaledNext   = {divReg, 1'b0};
  assign canShift     = !divReg[W-1] && ({1'b0, remReg} >= scaledNext);
  assign fits         = remReg >= divReg;
  assign markerAtBase = marker[0];
  assign divisorZero  = (divisorIn == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remReg  <= '0;
      divReg  <= '0;
      quotReg <= '0;
      marker  <= W'(1);
      dbzReg  <= 1'b0;
    end else if (strb.load) begin
      remReg  <= dividendIn;
      divReg  <= divisorIn;
      quotReg <= '0;
      marker  <= W'(1);
      dbzReg  <= 1'b0;
    end else if (strb.loadZero) begin
      remReg  <= dividendIn;
      divReg  <= divisorIn;
      quotReg <= '1;
      marker  <= W'(1);
      dbzReg  <= 1'b1;
    end else if (strb.shiftL) begin
      divReg <= divReg << 1;
      marker <= marker << 1;
    end else if (strb.step) begin
      if (fits) begin
        remReg  <= remReg - divReg;
        quotReg <= quotReg + marker;
      end
      if (!strb.lastStep) begin
        divReg <= divReg >> 1;
        marker <= marker >> 1;
      end
    end
  end

  assign quotient  = quotReg;
  assign remainder = remReg;
  assign divByZero = dbzReg;

  // R9
  marker_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(marker));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    strb.shiftL |-> !divReg[W-1]);

  // R1
  rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.step && strb.lastStep) |=> (remReg < divReg));

  // R2
  zero_result_chk: assert property (@(posedge clk) disable iff (rst)
    strb.loadZero |=> (dbzReg && quotReg == '1));
endmodule

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        canShift,
  input  logic        markerAtBase,
  input  logic        divisorZero,
  output divStrobes_t strb,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {IDLE, NORM, SUB} divState_t;

  divState_t state, stateNext;
  logic      doneReg, doneNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    doneNext  = 1'b0;
    unique case (state)
      IDLE: if (start) begin
        if (divisorZero) begin
          strb.loadZero = 1'b1;
          doneNext      = 1'b1;
        end else begin
          strb.load = 1'b1;
          stateNext = NORM;
        end
      end
      NORM: begin
        if (canShift) strb.shiftL = 1'b1;
        else          stateNext   = SUB;
      end
      SUB: begin
        strb.step     = 1'b1;
        strb.lastStep = markerAtBase;
        if (markerAtBase) begin
          stateNext = IDLE;
          doneNext  = 1'b1;
        end
      end
      default: stateNext = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= IDLE;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      doneReg <= doneNext;
    end
  end

  assign busy = (state != IDLE);
  assign done = doneReg;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  busy_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !divisorZero) |=> busy);

  // R2
  zero_immediate_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisorZero) |=> (done && !busy));
endmodule

// File: rtl/shiftSubDivider.sv
module shiftSubDivider
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         divByZero
);
  divStrobes_t strb;
  logic canShift, markerAtBase, divisorZero;

  divControl i_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .canShift(canShift), .markerAtBase(markerAtBase), .divisorZero(divisorZero),
    .strb(strb), .busy(busy), .done(done)
  );

  divDatapath #(.W(W)) i_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .dividendIn(dividend), .divisorIn(divisor),
    .canShift(canShift), .markerAtBase(markerAtBase), .divisorZero(divisorZero),
    .quotient(quotient), .remainder(remainder), .divByZero(divByZero)
  );
endmodule

// File: tb/test_shiftSubDivider.sv
module test_shiftSubDivider;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic         busy, done, divByZero;
  logic [W-1:0] quotient, remainder;

  always #4 clk = ~clk;  // 125 MHz

  shiftSubDivider #(.W(W)) i_shiftSubDivider (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .divByZero(divByZero)
  );

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         dbz;
    int           lat;
    string        tag;
  } expItem_t;

  expItem_t sbQueue[$];
  int checks = 0, errors = 0;
  int busyCnt = 0;
  logic prevDone = 1'b0;
  logic finished = 1'b0;

  function automatic int expLatency(logic [W-1:0] a, logic [W-1:0] b);
    logic [63:0] d;
    int s;
    if (b == '0) return 0;
    d = 64'(b);
    s = 0;
    while ((d << 1) <= 64'(a)) begin
      d = d << 1;
      s++;
    end
    return 2 * s + 2;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitIdle();
    while (busy || done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doDiv(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    expItem_t it;
    waitIdle();
    it.dbz = (b == '0);
    it.q   = it.dbz ? '1 : a / b;
    it.r   = it.dbz ? a : a % b;
    it.lat = expLatency(a, b);
    it.tag = tag;
    sbQueue.push_back(it);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prevDone)  // R3: one-cycle pulse
        check(!done, "R3", "done longer than one cycle", W'(done), '0);
      if (done) begin
        expItem_t it;
        check(!busy, "R3", "busy during done", W'(busy), '0);
        if (sbQueue.size() == 0) begin
          check(1'b0, "R4", "unexpected done", W'(1), '0);
        end else begin
          it = sbQueue.pop_front();
          check(quotient == it.q, it.tag, "quotient", quotient, it.q);
          check(remainder == it.r, it.tag, "remainder", remainder, it.r);
          check(divByZero == it.dbz, "R2", "divByZero", W'(divByZero), W'(it.dbz));
          check(busyCnt == it.lat, "R5", "busy cycles", W'(busyCnt), W'(it.lat));
        end
        busyCnt = 0;
      end else if (busy) begin
        busyCnt++;
      end
      prevDone = done;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(!busy, "R8", "busy after reset", W'(busy), '0);
    check(!done, "R8", "done after reset", W'(done), '0);
    check(!divByZero, "R8", "divByZero after reset", W'(divByZero), '0);
    check(quotient == '0, "R8", "quotient after reset", quotient, '0);
    check(remainder == '0, "R8", "remainder after reset", remainder, '0);

    doDiv(50, 10, "R1");
    doDiv(128, 4, "R1");
    doDiv(1156, 19, "R1");
    doDiv(3, 7, "R6");
    doDiv(0, 5, "R6");
    doDiv(32'h7FFF_FFFE, 32'hFFFF_FFFF, "R6");
    doDiv(12345, 0, "R2");
    doDiv(0, 0, "R2");
    doDiv(99, 99, "R1");
    doDiv(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    doDiv(32'hFFFF_FFFF, 1, "R1");
    doDiv(1, 1, "R1");
    doDiv(32'hFFFF_FFFF, 32'h8000_0000, "R7");
    doDiv(32'h8000_0000, 32'h8000_0000, "R7");
    doDiv(32'hC000_0001, 32'h8000_0001, "R7");
    doDiv(32'hFFFF_FFFF, 32'h4000_0000, "R7");

    // R4: start while busy must be ignored
    doDiv(32'hFFFF_FFFF, 3, "R4");
    repeat (3) @(negedge clk);
    dividend = 7;
    divisor  = 0;
    start    = 1'b1;
    @(negedge clk);
    dividend = 9;
    divisor  = 2;
    @(negedge clk);
    start    = 1'b0;

    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = $urandom >> ($urandom % 32);
      doDiv(a, b, "R1");
    end

    waitIdle();
    repeat (4) @(negedge clk);
    check(sbQueue.size() == 0, "R3", "results outstanding", W'(sbQueue.size()), '0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule